// File: doc/BRIEF.md
# DRAM Row/Column Address Sequencer

This block turns a flat 16-bit processor address into the two-phase address that a multiplexed-address DRAM expects. A request starts one access. The block latches the address and drives the high byte onto an 8-bit DRAM address bus. It then pulls the row strobe low. After a programmable number of cycles it moves the multiplexer select to the column side, so that the low byte appears on the bus. A further programmable delay later it pulls the column strobe low. The access ends with a precharge interval, during which both strobes are high and the select is back on the row side.

The select is a signal in its own right and is delayed after the row strobe. The row address therefore stays on the bus until the DRAM has captured it. The select is brought out as a port. A fault-injection input can pin the select to the row side. With the select pinned, every column phase repeats the row byte, which reproduces the aliasing failure in which a read returns the data of an earlier write to a different address. Ready pulses once per access, and read data is valid on that cycle. Requests that arrive while an access or its precharge is still running are dropped.

Top module: `dram_addr_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), ras_n and cas_n are 1, mux_col is 0 and ready is 0.
- R2: A request seen at a clock edge while the block is idle starts an access. From the next cycle ras_n is 0, cas_n is 1, mux_col is 0 and dram_addr equals the latched addr[15:8], for ROW_DLY cycles.
- R3: Exactly ROW_DLY cycles after ras_n falls, mux_col becomes 1 and dram_addr equals the latched addr[7:0]. cas_n stays 1 for COL_DLY cycles more.
- R4: cas_n is 0 for exactly CAS_CYC cycles, beginning ROW_DLY+COL_DLY cycles after ras_n falls. ras_n is 0 whenever cas_n is 0.
- R5: ready is 1 for exactly one cycle per access, the last cycle in which cas_n is 0.
- R6: After the column phase, ras_n and cas_n are both 1 and mux_col is 0 for PRE_CYC cycles before the block is idle again.
- R7: A request at any clock edge outside the idle state is ignored. It does not re-latch the address and does not change the timing of the running access.
- R8: While ras_n is 0, dram_we_n equals the inverse of we_in as latched with the request. Otherwise it is 1.
- R9: While fault_row_hold is 1, mux_col stays 0 and dram_addr shows the row byte in the column phase as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, sampled only while idle |
| addr | input | 16 | Flat processor address |
| we_in | input | 1 | 1 for a write access |
| fault_row_hold | input | 1 | Fault injection: holds the select on the row side |
| ready | output | 1 | One-cycle completion pulse |
| dram_addr | output | 8 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| mux_col | output | 1 | Multiplexer select, 1 selects the column byte |
| dram_we_n | output | 1 | DRAM write enable, active low |

## Verification
Two events can fall on the same clock edge: the end of precharge and a new request. A request that is already waiting must not be taken on the last precharge edge. It must be taken on the first idle edge. The bench provokes this by holding req high across several back-to-back accesses while the address changes, and by pulsing req in the middle of an access. A behavioural cycle counter in the bench decides on every clock which access is running and which byte must be on the bus. A second overlap occurs when the fault input is held during the column switch. The model predicts the select staying at row and the row byte repeating, and it judges this on the column cycles.

// File: rtl/dram_seq_pkg.sv
// Package: shared phase encoding for the DRAM address sequencer.
// Assumes: a single access in flight at any time.
package dram_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ROW    = 3'd1,
        PH_SWITCH = 3'd2,
        PH_COL    = 3'd3,
        PH_PRE    = 3'd4
    } phase_t;
endpackage

// File: rtl/dram_seq_timer.sv
// Module: down-counter that times the length of each phase.
// Assumes: load has priority; done is high while the count is zero.
module dram_seq_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] count;

    // Load a new phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    // Phase finished when the counter is exhausted.
    always_comb done = (count == '0);
endmodule

// File: rtl/dram_seq_fsm.sv
// Module: phase sequencer IDLE -> ROW -> SWITCH -> COL -> PRE -> IDLE.
// Assumes: every delay parameter is at least 1; req is only looked at in IDLE.
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int ROW_DLY = 2,
    parameter int COL_DLY = 1,
    parameter int CAS_CYC = 2,
    parameter int PRE_CYC = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    output phase_t phase,
    output logic   accept,
    output logic   ready
);
    localparam int MAX_A   = (ROW_DLY > COL_DLY) ? ROW_DLY : COL_DLY;
    localparam int MAX_B   = (CAS_CYC > PRE_CYC) ? CAS_CYC : PRE_CYC;
    localparam int MAX_DLY = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    phase_t           phase_d;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             done;

    dram_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    // Choose the next phase from the current one and the timer.
    always_comb begin
        phase_d = phase;
        case (phase)
            PH_IDLE:   if (req)  phase_d = PH_ROW;
            PH_ROW:    if (done) phase_d = PH_SWITCH;
            PH_SWITCH: if (done) phase_d = PH_COL;
            PH_COL:    if (done) phase_d = PH_PRE;
            PH_PRE:    if (done) phase_d = PH_IDLE;
            default:             phase_d = PH_IDLE;
        endcase
    end

    // Reload the timer with the length of the phase being entered.
    always_comb begin
        load = (phase_d != phase);
        case (phase_d)
            PH_ROW:    load_val = CNT_W'(ROW_DLY - 1);
            PH_SWITCH: load_val = CNT_W'(COL_DLY - 1);
            PH_COL:    load_val = CNT_W'(CAS_CYC - 1);
            PH_PRE:    load_val = CNT_W'(PRE_CYC - 1);
            default:   load_val = '0;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_IDLE;
        else
            phase <= phase_d;
    end

    // Handshake: take a request only when idle; ready on the last column cycle.
    always_comb begin
        accept = (phase == PH_IDLE) && req;
        ready  = (phase == PH_COL) && done;
    end
endmodule

// File: rtl/dram_addr_mux.sv
// Module: bank of narrow two-to-one multiplexers sharing one select.
// Assumes: ADDR_W/2 is a multiple of SLICE_W; select 0 gives the high half (row).
module dram_addr_mux #(
    parameter int ADDR_W  = 16,
    parameter int SLICE_W = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                sel_col,
    output logic [ADDR_W/2-1:0] mux_addr
);
    localparam int HALF_W = ADDR_W / 2;
    localparam int N_SLC  = HALF_W / SLICE_W;

    for (genvar g = 0; g < N_SLC; g++) begin : g_slice
        // One slice: row bits from the upper half, column bits from the lower half.
        always_comb begin
            mux_addr[g*SLICE_W +: SLICE_W] = sel_col ? addr[g*SLICE_W +: SLICE_W]
                                                     : addr[HALF_W + g*SLICE_W +: SLICE_W];
        end
    end
endmodule

// File: rtl/dram_addr_seq.sv
// Module: top of the DRAM row/column address sequencer.
// Assumes: one access at a time; strobes and select decode from the registered phase.
module dram_addr_seq
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SLICE_W = 4,
    parameter int ROW_DLY = 2,
    parameter int COL_DLY = 1,
    parameter int CAS_CYC = 2,
    parameter int PRE_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we_in,
    input  logic                fault_row_hold,
    output logic                ready,
    output logic [ADDR_W/2-1:0] dram_addr,
    output logic                ras_n,
    output logic                cas_n,
    output logic                mux_col,
    output logic                dram_we_n
);
    phase_t            phase;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic              row_active;

    dram_seq_fsm #(
        .ROW_DLY (ROW_DLY),
        .COL_DLY (COL_DLY),
        .CAS_CYC (CAS_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .phase  (phase),
        .accept (accept),
        .ready  (ready)
    );

    // Capture the address and direction of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= addr;
            we_q   <= we_in;
        end
    end

    // Decode strobes, select and write enable from the phase.
    always_comb begin
        row_active = (phase == PH_ROW) || (phase == PH_SWITCH) || (phase == PH_COL);
        ras_n      = ~row_active;
        cas_n      = ~(phase == PH_COL);
        mux_col    = ((phase == PH_SWITCH) || (phase == PH_COL)) && !fault_row_hold;
        dram_we_n  = ~(row_active && we_q);
    end

    dram_addr_mux #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W)) u_mux (
        .addr     (addr_q),
        .sel_col  (mux_col),
        .mux_addr (dram_addr)
    );
endmodule

// File: rtl/dram_addr_seq_chk.sv
// Module: protocol checker for the sequencer, attached by bind.
// Assumes: observes top-level ports only.
module dram_addr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic ras_n,
    input logic cas_n,
    input logic mux_col,
    input logic fault_row_hold,
    input logic dram_we_n
);
    // R2
    ras_fall_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!mux_col && cas_n));
    // R3
    cas_needs_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !fault_row_hold) |-> mux_col);
    // R4
    cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    // R5
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    // R5
    ready_in_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !cas_n);
    // R6
    ras_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (cas_n && !mux_col));
    // R8
    we_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |-> $stable(dram_we_n));
    // R9
    fault_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_row_hold |-> !mux_col);
endmodule

bind dram_addr_seq dram_addr_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ready          (ready),
    .ras_n          (ras_n),
    .cas_n          (cas_n),
    .mux_col        (mux_col),
    .fault_row_hold (fault_row_hold),
    .dram_we_n      (dram_we_n)
);

// File: tb/dram_addr_seq_tb.sv
`timescale 1ns/1ps
module dram_addr_seq_tb;
    localparam int RD = 2, SD = 1, CD = 2, PD = 2;
    localparam int TOTAL = RD + SD + CD + PD;

    logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, we_in = 1'b0, fault = 1'b0;
    logic [15:0] addr = 16'h0;
    logic        ready, ras_n, cas_n, mux_col, dram_we_n;
    logic [7:0]  dram_addr;

    int n_chk = 0, n_fail = 0, ready_cnt = 0;
    bit cmp_on = 1'b0, finished = 1'b0;

    // Behavioural reference: cycle index within the current access, -1 when idle.
    int          t = -1;
    logic [15:0] m_addr = 16'h0;
    logic        m_we = 1'b0;

    always #2 clk = ~clk;

    dram_addr_seq #(.ROW_DLY(RD), .COL_DLY(SD), .CAS_CYC(CD), .PRE_CYC(PD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .we_in(we_in),
        .fault_row_hold(fault), .ready(ready), .dram_addr(dram_addr),
        .ras_n(ras_n), .cas_n(cas_n), .mux_col(mux_col), .dram_we_n(dram_we_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the reference model on each edge.
    always @(posedge clk) begin
        if (!rst_n) t = -1;
        else if (t < 0) begin
            if (req) begin t = 0; m_addr = addr; m_we = we_in; end
        end else begin
            t = t + 1;
            if (t == TOTAL) t = -1;
        end
    end

    // Compare every output against the model away from the edge.
    always @(negedge clk) begin
        if (ready) ready_cnt++;
        if (cmp_on) begin
            bit in_row, in_sw, in_col, act, e_sel;
            string ptag;
            in_row = (t >= 0) && (t < RD);
            in_sw  = (t >= RD) && (t < RD + SD);
            in_col = (t >= RD + SD) && (t < RD + SD + CD);
            act    = in_row || in_sw || in_col;
            e_sel  = (in_sw || in_col) && !fault;
            ptag   = in_row ? "R2" : in_sw ? "R3" : in_col ? "R4" : "R6";
            chk({ptag, " ras_n"}, ras_n, !act);
            chk({ptag, " cas_n"}, cas_n, !in_col);
            chk(fault ? "R9 mux_col" : {ptag, " mux_col"}, mux_col, e_sel);
            chk("R5 ready", ready, t == RD + SD + CD - 1);
            chk("R8 dram_we_n", dram_we_n, !(act && m_we));
            if (act) chk({ptag, " dram_addr"}, dram_addr, e_sel ? m_addr[7:0] : m_addr[15:8]);
        end
    end

    // One access with explicit phase checks at the expected cycles.
    task automatic access(input logic [15:0] a, input logic w, input logic f);
        @(posedge clk); #1;
        req = 1'b1; addr = a; we_in = w; fault = f;
        ready_cnt = 0;
        @(posedge clk); #1;
        req = 1'b0; addr = ~a;
        chk("R2 ras low", ras_n, 0);
        chk("R2 row byte", dram_addr, a[15:8]);
        chk("R2 select row", mux_col, 0);
        repeat (RD) @(posedge clk);
        #1;
        chk(f ? "R9 select held" : "R3 select col", mux_col, !f);
        chk(f ? "R9 row byte repeats" : "R3 col byte", dram_addr, f ? a[15:8] : a[7:0]);
        chk("R3 cas waits", cas_n, 1);
        repeat (SD) @(posedge clk);
        #1;
        chk("R4 cas low", cas_n, 0);
        chk("R8 we", dram_we_n, !w);
        repeat (CD) @(posedge clk);
        #1;
        chk("R6 ras high", ras_n, 1);
        chk("R6 cas high", cas_n, 1);
        chk("R6 select row", mux_col, 0);
        repeat (PD) @(posedge clk);
        #1;
        chk("R5 one ready", ready_cnt, 1);
        fault = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 ras_n", ras_n, 1);
        chk("R1 cas_n", cas_n, 1);
        chk("R1 mux_col", mux_col, 0);
        chk("R1 ready", ready, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        access(16'h12AB, 1'b0, 1'b0);
        access(16'h34CD, 1'b1, 1'b0);
        access(16'hA55A, 1'b1, 1'b0);

        // R7: request mid-access with another address must be dropped.
        @(posedge clk); #1;
        req = 1'b1; addr = 16'h9A3C; we_in = 1'b0;
        @(posedge clk); #1;
        addr = 16'hFFFF; we_in = 1'b1;
        repeat (RD + SD) @(posedge clk);
        #1;
        chk("R7 col byte kept", dram_addr, 8'h3C);
        chk("R7 we kept", dram_we_n, 1);
        req = 1'b0;
        repeat (TOTAL) @(posedge clk);

        // R7: request held high across back-to-back accesses.
        @(posedge clk); #1;
        req = 1'b1;
        for (int i = 0; i < 4 * TOTAL; i++) begin
            addr = 16'h0F0F + 16'(i * 16'h1111);
            we_in = i[0];
            @(posedge clk); #1;
        end
        req = 1'b0;
        repeat (TOTAL) @(posedge clk);

        // R9: stuck select reproduces the row/column aliasing.
        access(16'h5678, 1'b1, 1'b0);
        access(16'h5678, 1'b0, 1'b1);
        access(16'h56EE, 1'b0, 1'b1);

        // R1: reset in the middle of an access returns the strobes to idle.
        @(posedge clk); #1;
        req = 1'b1; addr = 16'h2468;
        @(posedge clk); #1;
        req = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 ras after reset", ras_n, 1);
        chk("R1 cas after reset", cas_n, 1);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule